// File: doc/BRIEF.md
# Capability Execution Mode Controller

This block decides, every cycle, which of three execution modes a capability-extended core is running in. It also adapts accesses to a capability control register to that mode. Two modes are narrow: Legacy and Semi-legacy. One is wide: Capability. Legacy is forced whenever the running integer width is below the widest supported width, or when the capability-mode enable for the current privilege level is off. Otherwise the mode bit of the program-counter capability chooses between Capability (bit clear) and Semi-legacy (bit set). Debug execution always runs in Capability mode. When strict decoding is claimed, a capability instruction met in Legacy mode is flagged as illegal.

The block holds one capability register: a tag bit, a metadata field and an address. In Capability mode, software reads and writes the whole capability. In the narrow modes, the access width follows from the mode instead of a separate register alias. A read returns only the address, sign-extended from the running width. A write, or a set or clear bit operation, sign-extends the integer operand and replaces the address of the old capability. The tag survives this replacement only if the capability is unsealed and the new address is representable. The representability result is supplied by the bounds logic outside this block.

The mode decode is combinational and produces a named mode value: LEGACY, CAPABILITY or SEMI_LEGACY. Three rules move it between values. The forced-narrow condition drives it to LEGACY. When that condition is clear, the pcc mode bit selects between CAPABILITY and SEMI_LEGACY. The debug flag overrides both and selects CAPABILITY. The only clocked state is the capability register. It updates on a clock edge when the write enable is high.

Top module: `cme_ctrl`

## Requirements
- R1: `mode_o` encodes LEGACY as 2'b00, CAPABILITY as 2'b01 and SEMI_LEGACY as 2'b10, and never takes the value 2'b11.
- R2: Outside debug, `mode_o` is LEGACY whenever `eff_xlen` < `max_xlen` or `cme_en` is 0.
- R3: Outside debug, when Legacy is not forced, `mode_o` is CAPABILITY if `pcc_m` is 0 and SEMI_LEGACY if `pcc_m` is 1.
- R4: While `dbg_mode` is 1, `mode_o` is CAPABILITY regardless of every other input.
- R5: `illegal_o` is combinational and equals `strict_dec` AND `is_cap_insn` AND (mode is LEGACY); it is 0 whenever `strict_dec` is 0.
- R6: In LEGACY or SEMI_LEGACY, `rd_int` is the register address with bits at and above position `eff_xlen` replaced by bit `eff_xlen`-1.
- R7: A narrow-mode write with `csr_op` 2'b00 (or 2'b11, also a plain write) sets the address to `wr_int` sign-extended from `eff_xlen` bits.
- R8: A narrow-mode write with `csr_op` 2'b01 sets the address to sext(old address) OR sext(`wr_int`). With `csr_op` 2'b10 it sets sext(old address) AND NOT sext(`wr_int`). Both sign extensions are from `eff_xlen` bits.
- R9: A narrow-mode write keeps the metadata unchanged. It clears the tag if metadata bit 0 (the sealed bit, 1 = sealed) is 1 or `repr_ok` is 0; otherwise the tag is kept. A narrow-mode write never sets the tag.
- R10: In CAPABILITY mode, a write replaces tag, metadata and address with `wr_cap_tag`, `wr_cap_meta` and `wr_cap_addr`; `csr_op`, `wr_int` and `repr_ok` have no effect, and `rd_int` shows the full address.
- R11: The register changes only on a rising clock edge with `csr_we` high, and holds its value otherwise.
- R12: After reset the register holds tag 0, metadata 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eff_xlen | input | LW | Current integer width in bits |
| max_xlen | input | LW | Widest supported integer width in bits |
| cme_en | input | 1 | Capability-mode enable for the current privilege |
| pcc_m | input | 1 | Mode bit of the program-counter capability |
| dbg_mode | input | 1 | Core is in debug execution |
| strict_dec | input | 1 | Strict decoding of reserved encodings is claimed |
| is_cap_insn | input | 1 | Decoded instruction belongs to the capability set |
| mode_o | output | 2 | Current execution mode code |
| illegal_o | output | 1 | Illegal-instruction indication |
| csr_we | input | 1 | Capability register write enable |
| csr_op | input | 2 | 00 write, 01 set bits, 10 clear bits, 11 write |
| wr_int | input | ADDR_W | Integer operand for narrow-mode writes |
| wr_cap_tag | input | 1 | Tag of full capability written in Capability mode |
| wr_cap_meta | input | META_W | Metadata of full capability written in Capability mode |
| wr_cap_addr | input | ADDR_W | Address of full capability written in Capability mode |
| repr_ok | input | 1 | New address is representable within the bounds |
| rd_int | output | ADDR_W | Integer view of the register for the current mode |
| rd_tag | output | 1 | Register tag |
| rd_meta | output | META_W | Register metadata |
| rd_addr | output | ADDR_W | Register address |

## Verification
A wrong mode decode shows up in the same cycle on `mode_o` and `illegal_o`. A wrong mode also changes the read view `rd_int` in that cycle, since the read format depends on the mode. An error in the merge path or in the tag rule appears on `rd_tag`, `rd_meta` and `rd_addr` at the first sample after the write edge. If the register changes without a write enable, its outputs move one edge after that edge. The sweeps cover every control combination for every running width, and every write form under sealed, unsealed, representable and unrepresentable conditions. Each fault is therefore observed within one cycle of the stimulus that exposes it.

// File: rtl/cme_pkg.sv
package cme_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY      = 2'b00,
        MODE_CAPABILITY  = 2'b01,
        MODE_SEMI_LEGACY = 2'b10
    } exec_mode_e;

    typedef enum logic [1:0] {
        OP_WRITE     = 2'b00,
        OP_SET       = 2'b01,
        OP_CLEAR     = 2'b10,
        OP_WRITE_ALT = 2'b11
    } csr_op_e;

endpackage

// File: rtl/cme_sext.sv
module cme_sext #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic [W-1:0]  val_i,
    input  logic [LW-1:0] width_i,
    output logic [W-1:0]  val_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [IW-1:0] sign_idx;

    always_comb begin
        if (width_i == '0) begin
            sign_idx = '0;
        end else if (width_i > LW'(W)) begin
            sign_idx = IW'(W - 1);
        end else begin
            sign_idx = IW'(width_i - LW'(1));
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign val_o[b] = (LW'(b) < width_i) ? val_i[b] : val_i[sign_idx];
    end

endmodule

// File: rtl/cme_mode_decode.sv
module cme_mode_decode
    import cme_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic [LW-1:0] eff_xlen,
    input  logic [LW-1:0] max_xlen,
    input  logic          cme_en,
    input  logic          pcc_m,
    input  logic          dbg_mode,
    input  logic          strict_dec,
    input  logic          is_cap_insn,
    output exec_mode_e    mode,
    output logic          illegal
);
    logic forced_narrow;

    assign forced_narrow = (eff_xlen < max_xlen) || !cme_en;

    always_comb begin
        unique casez ({dbg_mode, forced_narrow, pcc_m})
            3'b1??:  mode = MODE_CAPABILITY;
            3'b01?:  mode = MODE_LEGACY;
            3'b001:  mode = MODE_SEMI_LEGACY;
            default: mode = MODE_CAPABILITY;
        endcase
    end

    always_comb begin
        illegal = 1'b0;
        if (strict_dec && is_cap_insn) begin
            unique case (mode)
                MODE_LEGACY:      illegal = 1'b1;
                MODE_CAPABILITY:  illegal = 1'b0;
                MODE_SEMI_LEGACY: illegal = 1'b0;
                default:          illegal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cme_csr_path.sv
module cme_csr_path
    import cme_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int META_W = 4,
    parameter int LW     = 5
) (
    input  exec_mode_e        mode,
    input  logic [1:0]        csr_op,
    input  logic [LW-1:0]     eff_xlen,
    input  logic              cur_tag,
    input  logic [META_W-1:0] cur_meta,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] wr_int,
    input  logic              wr_cap_tag,
    input  logic [META_W-1:0] wr_cap_meta,
    input  logic [ADDR_W-1:0] wr_cap_addr,
    input  logic              repr_ok,
    output logic [ADDR_W-1:0] cur_addr_ext,
    output logic              nxt_tag,
    output logic [META_W-1:0] nxt_meta,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0] wr_ext;
    logic [ADDR_W-1:0] merged_addr;
    logic              sealed;

    cme_sext #(.W(ADDR_W), .LW(LW)) u_sext_old (
        .val_i   (cur_addr),
        .width_i (eff_xlen),
        .val_o   (cur_addr_ext)
    );

    cme_sext #(.W(ADDR_W), .LW(LW)) u_sext_new (
        .val_i   (wr_int),
        .width_i (eff_xlen),
        .val_o   (wr_ext)
    );

    assign sealed = cur_meta[0];

    always_comb begin
        unique case (csr_op_e'(csr_op))
            OP_SET:   merged_addr = cur_addr_ext | wr_ext;
            OP_CLEAR: merged_addr = cur_addr_ext & ~wr_ext;
            default:  merged_addr = wr_ext;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_CAPABILITY: begin
                nxt_tag  = wr_cap_tag;
                nxt_meta = wr_cap_meta;
                nxt_addr = wr_cap_addr;
            end
            default: begin
                nxt_tag  = cur_tag && !sealed && repr_ok;
                nxt_meta = cur_meta;
                nxt_addr = merged_addr;
            end
        endcase
    end

endmodule

// File: rtl/cme_ctrl.sv
module cme_ctrl
    import cme_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int META_W = 4,
    parameter int LW     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LW-1:0]     eff_xlen,
    input  logic [LW-1:0]     max_xlen,
    input  logic              cme_en,
    input  logic              pcc_m,
    input  logic              dbg_mode,
    input  logic              strict_dec,
    input  logic              is_cap_insn,
    output logic [1:0]        mode_o,
    output logic              illegal_o,
    input  logic              csr_we,
    input  logic [1:0]        csr_op,
    input  logic [ADDR_W-1:0] wr_int,
    input  logic              wr_cap_tag,
    input  logic [META_W-1:0] wr_cap_meta,
    input  logic [ADDR_W-1:0] wr_cap_addr,
    input  logic              repr_ok,
    output logic [ADDR_W-1:0] rd_int,
    output logic              rd_tag,
    output logic [META_W-1:0] rd_meta,
    output logic [ADDR_W-1:0] rd_addr
);
    exec_mode_e        cur_mode;
    logic              cap_tag_q,  cap_tag_d;
    logic [META_W-1:0] cap_meta_q, cap_meta_d;
    logic [ADDR_W-1:0] cap_addr_q, cap_addr_d;
    logic [ADDR_W-1:0] addr_ext;

    cme_mode_decode #(.LW(LW)) u_mode (
        .eff_xlen    (eff_xlen),
        .max_xlen    (max_xlen),
        .cme_en      (cme_en),
        .pcc_m       (pcc_m),
        .dbg_mode    (dbg_mode),
        .strict_dec  (strict_dec),
        .is_cap_insn (is_cap_insn),
        .mode        (cur_mode),
        .illegal     (illegal_o)
    );

    cme_csr_path #(.ADDR_W(ADDR_W), .META_W(META_W), .LW(LW)) u_path (
        .mode         (cur_mode),
        .csr_op       (csr_op),
        .eff_xlen     (eff_xlen),
        .cur_tag      (cap_tag_q),
        .cur_meta     (cap_meta_q),
        .cur_addr     (cap_addr_q),
        .wr_int       (wr_int),
        .wr_cap_tag   (wr_cap_tag),
        .wr_cap_meta  (wr_cap_meta),
        .wr_cap_addr  (wr_cap_addr),
        .repr_ok      (repr_ok),
        .cur_addr_ext (addr_ext),
        .nxt_tag      (cap_tag_d),
        .nxt_meta     (cap_meta_d),
        .nxt_addr     (cap_addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_tag_q  <= 1'b0;
            cap_meta_q <= '0;
            cap_addr_q <= '0;
        end else if (csr_we) begin
            cap_tag_q  <= cap_tag_d;
            cap_meta_q <= cap_meta_d;
            cap_addr_q <= cap_addr_d;
        end
    end

    always_comb begin
        mode_o = cur_mode;
        unique case (cur_mode)
            MODE_CAPABILITY: rd_int = cap_addr_q;
            default:         rd_int = addr_ext;
        endcase
    end

    assign rd_tag  = cap_tag_q;
    assign rd_meta = cap_meta_q;
    assign rd_addr = cap_addr_q;

endmodule

// File: rtl/cme_ctrl_chk.sv
module cme_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int META_W = 4,
    parameter int LW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LW-1:0]     eff_xlen,
    input logic [LW-1:0]     max_xlen,
    input logic              cme_en,
    input logic              dbg_mode,
    input logic              strict_dec,
    input logic [1:0]        mode_o,
    input logic              illegal_o,
    input logic              csr_we,
    input logic              wr_cap_tag,
    input logic [META_W-1:0] wr_cap_meta,
    input logic [ADDR_W-1:0] wr_cap_addr,
    input logic              rd_tag,
    input logic [META_W-1:0] rd_meta,
    input logic [ADDR_W-1:0] rd_addr
);
    p_mode_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);

    p_forced_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && (!cme_en || eff_xlen < max_xlen)) |-> mode_o == 2'b00);

    p_debug_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> mode_o == 2'b01);

    p_no_strict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strict_dec |-> !illegal_o);

    p_narrow_meta_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && mode_o != 2'b01) |=> (rd_meta == $past(rd_meta)) && !(rd_tag && !$past(rd_tag)));

    p_wide_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && mode_o == 2'b01) |=> (rd_tag == $past(wr_cap_tag)) &&
            (rd_meta == $past(wr_cap_meta)) && (rd_addr == $past(wr_cap_addr)));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable({rd_tag, rd_meta, rd_addr}));

endmodule

bind cme_ctrl cme_ctrl_chk #(.ADDR_W(ADDR_W), .META_W(META_W), .LW(LW)) chk_i (.*);

// File: tb/cme_ctrl_tb.sv
module cme_ctrl_tb_top;
    localparam int AW = 16;
    localparam int MW = 4;
    localparam int LW = $clog2(AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] eff_xlen = LW'(AW);
    logic [LW-1:0] max_xlen = LW'(AW);
    logic          cme_en = 1'b1, pcc_m = 1'b0, dbg_mode = 1'b0;
    logic          strict_dec = 1'b0, is_cap_insn = 1'b0;
    logic [1:0]    mode_o;
    logic          illegal_o;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_op = 2'b00;
    logic [AW-1:0] wr_int = '0;
    logic          wr_cap_tag = 1'b0;
    logic [MW-1:0] wr_cap_meta = '0;
    logic [AW-1:0] wr_cap_addr = '0;
    logic          repr_ok = 1'b1;
    logic [AW-1:0] rd_int;
    logic          rd_tag;
    logic [MW-1:0] rd_meta;
    logic [AW-1:0] rd_addr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cme_ctrl #(.ADDR_W(AW), .META_W(MW)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] bsext(input logic [AW-1:0] v, input int xl);
        logic signed [AW-1:0] t;
        t = v << (AW - xl);
        return t >>> (AW - xl);
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] pa [6] = '{16'h8F3C, 16'h0071, 16'hFFFF, 16'h4A80, 16'h7F7F, 16'h1234};
        logic [AW-1:0] pw [6] = '{16'h00F0, 16'hFF81, 16'h5A5A, 16'h0008, 16'hC3C3, 16'h7FFF};
        logic [AW-1:0] hold_addr;
        logic [MW-1:0] hold_meta;
        logic          hold_tag;

        repeat (3) @(negedge clk);
        chk(rd_tag == 1'b0, "R12 tag", 32'(rd_tag), 0);
        chk(rd_meta == '0, "R12 meta", 32'(rd_meta), 0);
        chk(rd_addr == '0, "R12 addr", 32'(rd_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mode decode sweep; register must hold throughout (R11)
        for (int mx = 12; mx <= 16; mx += 4) begin
            for (int ex = 1; ex <= 16; ex++) begin
                for (int b = 0; b < 32; b++) begin
                    logic [1:0] em;
                    logic ei;
                    max_xlen = LW'(mx); eff_xlen = LW'(ex);
                    cme_en = b[0]; pcc_m = b[1]; dbg_mode = b[2];
                    strict_dec = b[3]; is_cap_insn = b[4];
                    #1;
                    if (b[2]) em = 2'b01;
                    else if (ex < mx || !b[0]) em = 2'b00;
                    else em = b[1] ? 2'b10 : 2'b01;
                    ei = b[3] && b[4] && (em == 2'b00);
                    chk(mode_o == em, b[2] ? "R4 debug mode" : (em == 2'b00 ? "R2 forced legacy" : "R3 pcc select"), 32'(mode_o), 32'(em));
                    chk(mode_o != 2'b11, "R1 code", 32'(mode_o), 0);
                    chk(illegal_o == ei, "R5 illegal", 32'(illegal_o), 32'(ei));
                    @(negedge clk);
                end
            end
        end
        chk(rd_addr == '0 && rd_tag == 1'b0, "R11 hold", 32'(rd_addr), 0);
        dbg_mode = 1'b0; strict_dec = 1'b0; is_cap_insn = 1'b0;

        // Register access sweep
        foreach (pa[k]) begin end
        for (int xi = 0; xi < 4; xi++) begin
            for (int md = 0; md < 3; md++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int k = 0; k < 6; k++) begin
                        int xl;
                        logic [AW-1:0] ea;
                        logic [MW-1:0] em;
                        logic et;
                        xl = (xi == 0) ? 4 : (xi == 1) ? 8 : (xi == 2) ? 13 : 16;
                        // preload in Capability mode
                        eff_xlen = LW'(xl); max_xlen = LW'(xl);
                        cme_en = 1'b1; pcc_m = 1'b0;
                        csr_we = 1'b1; csr_op = 2'(op);
                        wr_cap_tag = 1'b1;
                        wr_cap_meta = MW'(k * 5 + op);
                        wr_cap_addr = pa[k] ^ 16'(xi * 16'h1111);
                        wr_int = pw[k];
                        repr_ok = k[0];
                        @(negedge clk);
                        chk(rd_tag == 1'b1 && rd_meta == wr_cap_meta && rd_addr == wr_cap_addr,
                            "R10 full write", {15'd0, rd_tag, rd_addr}, {15'd0, 1'b1, wr_cap_addr});
                        chk(rd_int == rd_addr, "R10 full read", 32'(rd_int), 32'(wr_cap_addr));
                        hold_addr = rd_addr; hold_meta = rd_meta; hold_tag = rd_tag;

                        // access in selected mode
                        cme_en = (md != 0);
                        pcc_m  = (md == 2);
                        wr_cap_tag = k[1];
                        wr_cap_meta = MW'(~k);
                        wr_cap_addr = pw[5 - k];
                        repr_ok = (k % 3) != 0;
                        wr_int = pw[k] ^ 16'(op * 16'h0303);
                        #1;
                        if (md != 1)
                            chk(rd_int == bsext(hold_addr, xl), "R6 narrow read", 32'(rd_int), 32'(bsext(hold_addr, xl)));
                        @(negedge clk);
                        if (md == 1) begin
                            ea = wr_cap_addr; em = wr_cap_meta; et = wr_cap_tag;
                        end else begin
                            if (op == 1) ea = bsext(hold_addr, xl) | bsext(wr_int, xl);
                            else if (op == 2) ea = bsext(hold_addr, xl) & ~bsext(wr_int, xl);
                            else ea = bsext(wr_int, xl);
                            em = hold_meta;
                            et = hold_tag && !hold_meta[0] && repr_ok;
                        end
                        chk(rd_addr == ea, md == 1 ? "R10 op ignored" : (op == 1 || op == 2 ? "R8 bitwise merge" : "R7 write merge"),
                            32'(rd_addr), 32'(ea));
                        chk(rd_meta == em, md == 1 ? "R10 meta" : "R9 meta kept", 32'(rd_meta), 32'(em));
                        chk(rd_tag == et, md == 1 ? "R10 tag" : "R9 tag rule", 32'(rd_tag), 32'(et));
                        csr_we = 1'b0;
                        wr_cap_addr = ~wr_cap_addr;
                        wr_int = ~wr_int;
                        @(negedge clk);
                        chk(rd_addr == ea && rd_tag == et, "R11 no write", 32'(rd_addr), 32'(ea));
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule